// File: doc/BRIEF.md
# Planar Memory Read Path with Display Latch

This block sits on the read side of a four-plane video memory. Each time the memory returns a 32-bit word, the block copies the whole word into a display latch. It also reduces the word to one byte for the host. The write path uses the latch value as its second operand. The byte is produced in one of two ways.

- **Plane select (mode 0):** one plane byte is picked. The choice comes from a programmed plane number, and the low read address can override it in the packed-pixel and interleaved addressing modes.
- **Color compare (mode 1):** each of the eight pixel positions is tested against a 4-bit reference color. Planes can be left out of the test through a participation mask.

Both the latch and the host byte are registered. They change on the clock edge where the read strobe is high and hold their value otherwise.

Top module: `planar_read_unit`

## Requirements
- R1: On a clock edge with `rd_valid` high, `latch_q` takes all 32 bits of `rd_data` and shows them after that edge.
- R2: On a clock edge with `rd_valid` low, `latch_q` and `host_byte` keep their previous values, whatever the other inputs do.
- R3: While `rst_n` is low, `latch_q` and `host_byte` are cleared to zero.
- R4: Plane b occupies `rd_data[8b+7:8b]`. In mode 0 (`rd_mode`=0) with `chain4` and `odd_even` both low, `host_byte` becomes the byte of plane `map_sel`.
- R5: In mode 0 with `chain4` high, `host_byte` becomes the byte of plane `rd_addr_lo`, and `map_sel` is ignored.
- R6: In mode 0 with `odd_even` high and `chain4` low, the plane index is {`map_sel[1]`, `rd_addr_lo[0]`}.
- R7: When `chain4` and `odd_even` are both high in mode 0, the `chain4` addressing of R5 applies.
- R8: In mode 1 (`rd_mode`=1), bit n of `host_byte` is 1 only if bit n of every participating plane byte b equals `cmp_color[b]`.
- R9: A plane b with `care_mask[b]`=0 always counts as matching in mode 1, so its data and its `cmp_color` bit have no effect.
- R10: In mode 1 with `care_mask`=0, `host_byte` becomes 8'hFF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rd_valid | input | 1 | Memory read data valid |
| rd_data | input | 32 | Four plane bytes, plane 0 in the low byte |
| rd_addr_lo | input | 2 | Low read address bits |
| rd_mode | input | 1 | 0 = plane select, 1 = color compare |
| map_sel | input | 2 | Programmed plane number |
| chain4 | input | 1 | Packed-pixel addressing: address picks the plane |
| odd_even | input | 1 | Interleaved addressing: address bit 0 replaces the low select bit |
| cmp_color | input | 4 | Reference color, one bit per plane |
| care_mask | input | 4 | 1 = plane takes part in the comparison |
| host_byte | output | 8 | Byte returned to the host |
| latch_q | output | 32 | Display latch contents |

## Verification
The bench sets `chain4` and `odd_even` together. A design that gave the interleaved mode priority would then return the wrong plane whenever `map_sel[1]` differs from `rd_addr_lo[1]`. It drives color-compare reads with an empty participation mask, with single-plane masks and with reference colors that do not match. A design that inverts the mask, or that lets an excluded plane veto a match, returns bytes with bits cleared where they should be set. Idle cycles carry changing data and changing controls. A latch or output that is not gated by the strobe picks up this data and is caught.

// File: rtl/planar_read_unit.sv
module planar_read_unit #(
  parameter int PLANES = 4,
  parameter int PW     = 8,
  localparam int DW    = PLANES * PW,
  localparam int SW    = $clog2(PLANES)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          rd_valid,
  input  logic [DW-1:0] rd_data,
  input  logic [SW-1:0] rd_addr_lo,
  input  logic          rd_mode,
  input  logic [SW-1:0] map_sel,
  input  logic          chain4,
  input  logic          odd_even,
  input  logic [PLANES-1:0] cmp_color,
  input  logic [PLANES-1:0] care_mask,
  output logic [PW-1:0] host_byte,
  output logic [DW-1:0] latch_q
);

  logic [SW-1:0] plane_idx;
  logic [PW-1:0] sel_byte;
  logic [PW-1:0] cmp_byte;

  always_comb begin
    if (chain4)        plane_idx = rd_addr_lo;
    else if (odd_even) plane_idx = {map_sel[SW-1:1], rd_addr_lo[0]};
    else               plane_idx = map_sel;
  end

  assign sel_byte = rd_data[plane_idx*PW +: PW];

  always_comb begin
    for (int n = 0; n < PW; n++) begin
      cmp_byte[n] = 1'b1;
      for (int b = 0; b < PLANES; b++)
        if (care_mask[b] && (rd_data[b*PW+n] != cmp_color[b]))
          cmp_byte[n] = 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      latch_q   <= '0;
      host_byte <= '0;
    end else if (rd_valid) begin
      latch_q   <= rd_data;
      host_byte <= rd_mode ? cmp_byte : sel_byte;
    end
  end

  p_latch_load_r1: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |=> latch_q == $past(rd_data));

  p_idle_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_valid |=> $stable(latch_q) && $stable(host_byte));

  p_reset_clear_r3: assert property (@(posedge clk)
    !rst_n |=> latch_q == '0 && host_byte == '0);

  p_chain4_plane_r5: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid && !rd_mode && chain4 |=>
      host_byte == PW'($past(rd_data) >> ($past(rd_addr_lo) * PW)));

  p_all_excluded_r10: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid && rd_mode && care_mask == '0 |=> host_byte == '1);

endmodule

// File: tb/planar_read_unit_tb.sv
module planar_read_unit_tb;
  logic        clk = 0;
  logic        rst_n = 0;
  logic        rd_valid = 0;
  logic [31:0] rd_data = 0;
  logic [1:0]  rd_addr_lo = 0;
  logic        rd_mode = 0;
  logic [1:0]  map_sel = 0;
  logic        chain4 = 0;
  logic        odd_even = 0;
  logic [3:0]  cmp_color = 0;
  logic [3:0]  care_mask = 0;
  logic [7:0]  host_byte;
  logic [31:0] latch_q;

  int errors = 0;
  int checks = 0;

  always #2.5 clk = ~clk;

  planar_read_unit u_dut (
    .clk(clk), .rst_n(rst_n), .rd_valid(rd_valid), .rd_data(rd_data),
    .rd_addr_lo(rd_addr_lo), .rd_mode(rd_mode), .map_sel(map_sel),
    .chain4(chain4), .odd_even(odd_even), .cmp_color(cmp_color),
    .care_mask(care_mask), .host_byte(host_byte), .latch_q(latch_q)
  );

  function automatic logic [7:0] model_byte(logic [31:0] d, logic [1:0] a, logic m,
      logic [1:0] s, logic c4, logic oe, logic [3:0] col, logic [3:0] care);
    logic [1:0] p;
    logic [7:0] r;
    if (!m) begin
      p = c4 ? a : (oe ? {s[1], a[0]} : s);
      return d[p*8 +: 8];
    end
    r = 8'hFF;
    for (int n = 0; n < 8; n++)
      for (int b = 0; b < 4; b++)
        if (care[b] && d[b*8+n] != col[b]) r[n] = 1'b0;
    return r;
  endfunction

  function automatic string tag_of(logic m, logic c4, logic oe, logic [3:0] care);
    if (m) return (care == 0) ? "R10" : (care != 4'hF ? "R9" : "R8");
    if (c4 && oe) return "R7";
    if (c4) return "R5";
    if (oe) return "R6";
    return "R4";
  endfunction

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  logic [31:0] exp_latch = 0;
  logic [7:0]  exp_byte = 0;

  task automatic do_read(logic [31:0] d, logic [1:0] a, logic m, logic [1:0] s,
      logic c4, logic oe, logic [3:0] col, logic [3:0] care);
    string t;
    rd_valid = 1; rd_data = d; rd_addr_lo = a; rd_mode = m; map_sel = s;
    chain4 = c4; odd_even = oe; cmp_color = col; care_mask = care;
    exp_latch = d;
    exp_byte = model_byte(d, a, m, s, c4, oe, col, care);
    t = tag_of(m, c4, oe, care);
    @(posedge clk); @(negedge clk);
    rd_valid = 0;
    chk("R1", latch_q, exp_latch);
    chk(t, {24'h0, host_byte}, {24'h0, exp_byte});
  endtask

  task automatic do_idle();
    rd_valid = 0; rd_data = $urandom; rd_addr_lo = 2'($urandom);
    rd_mode = 1'($urandom); map_sel = 2'($urandom); chain4 = 1'($urandom);
    odd_even = 1'($urandom); cmp_color = 4'($urandom); care_mask = 4'($urandom);
    @(posedge clk); @(negedge clk);
    chk("R2", latch_q, exp_latch);
    chk("R2", {24'h0, host_byte}, {24'h0, exp_byte});
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=running expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    void'($urandom(32'h5EED_1234));
    rd_valid = 1; rd_data = 32'hDEADBEEF;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R3", latch_q, 32'h0);
    chk("R3", {24'h0, host_byte}, 32'h0);
    rd_valid = 0;
    rst_n = 1;
    @(negedge clk);

    do_read(32'h44332211, 2'd0, 0, 2'd2, 0, 0, 4'h0, 4'h0);
    do_read(32'h44332211, 2'd1, 0, 2'd0, 1, 0, 4'h0, 4'h0);
    do_read(32'h44332211, 2'd3, 0, 2'd0, 0, 1, 4'h0, 4'h0);
    do_read(32'h44332211, 2'd0, 0, 2'd3, 0, 1, 4'h0, 4'h0);
    do_read(32'h44332211, 2'd1, 0, 2'd2, 1, 1, 4'h0, 4'h0);
    do_read(32'h44332211, 2'd2, 0, 2'd1, 1, 1, 4'h0, 4'h0);
    do_idle();
    do_read(32'h00FF0F55, 2'd0, 1, 2'd0, 0, 0, 4'h5, 4'h0);
    do_read(32'hF0F0F0F0, 2'd0, 1, 2'd0, 0, 0, 4'hF, 4'hF);
    do_read(32'hF00FF00F, 2'd0, 1, 2'd0, 0, 0, 4'h5, 4'hF);
    do_read(32'hA5000000, 2'd0, 1, 2'd0, 0, 0, 4'h0, 4'h7);
    do_read(32'h12345678, 2'd0, 1, 2'd0, 0, 0, 4'hA, 4'h1);
    do_idle();
    do_idle();

    for (int i = 0; i < 600; i++) begin
      if ($urandom_range(3) == 0) do_idle();
      else do_read($urandom, 2'($urandom), 1'($urandom), 2'($urandom),
                   1'($urandom), 1'($urandom), 4'($urandom), 4'($urandom));
    end

    rst_n = 0;
    @(posedge clk); @(negedge clk);
    chk("R3", latch_q, 32'h0);
    chk("R3", {24'h0, host_byte}, 32'h0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule